// File: doc/BRIEF.md
# Diagnostic Telemetry Frame Serializer

This block sends one diagnostic frame of a four-channel touch-sense front end over a single-wire asynchronous serial link. A frame opens with a two-byte header and a revision field. Next come each channel's parasitic capacitance, three groups of unsigned 16-bit values (raw count, baseline, difference count), a channel status byte and an output status byte. A three-byte trailer closes it. Every multi-byte value goes out high byte first, and channels go out in ascending order inside each group.

The frame is sent on exactly one of four per-channel lines. Each channel has a request input that asks for debug output. When more than one is raised, the lowest-numbered channel wins. A start strobe snapshots every data input and the chosen line, and the block then serializes all 41 bytes as 8N1 characters. Each bit lasts a parameterised number of clock cycles. `busy_o` stays high for the whole frame.

Top module: `telem_frame_tx`

## Requirements
- R1: A frame starts with byte 0x0D followed by byte 0x0A.
- R2: Bytes 2 and 3 of a frame are 0x00 and the revision input.
- R3: Bytes 4 to 11 are, for channels 0 to 3 in turn, a 0x00 byte and then that channel's capacitance byte (`cap_i[8c+7:8c]`).
- R4: Bytes 12 to 35 form three groups in this order: raw count, baseline, difference count. Each group holds channels 0 to 3 in turn, each as 16-bit word bits [15:8] and then bits [7:0] (`word_i[16c+15:16c]`).
- R5: Byte 36 is the channel status input and byte 37 is the output status input.
- R6: Bytes 38, 39 and 40 are 0x00, 0xFF, 0xFF, and the frame holds exactly 41 bytes.
- R7: Each byte is sent as one low start bit, eight data bits least significant first, and one high stop bit, each held for CLKS_PER_BIT cycles. The start bit of byte 0 appears in the cycle after the accepting clock edge, and bytes follow with no gap.
- R8: The frame goes out on `tx_o[k]`, where k is the lowest index set in `req_i` at the accepting edge. Later changes of `req_i` do not move it.
- R9: Every line other than the selected one, and every line while idle, is held high (1).
- R10: `busy_o` rises in the cycle after the accepting edge and stays high for exactly 410 × CLKS_PER_BIT cycles.
- R11: A start that arrives while `busy_o` is high, or while `req_i` is all zero, starts no frame. A start held high across the end of a frame starts the next frame at the first edge where `busy_o` is low.
- R12: All data inputs are captured at the accepting edge. Changing them during a frame does not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start strobe |
| req_i | input | NCH | Per-channel debug output request |
| fw_rev_i | input | 8 | Revision byte |
| cap_i | input | NCH*8 | Parasitic capacitance per channel (pF) |
| raw_i | input | NCH*16 | Raw count per channel |
| base_i | input | NCH*16 | Baseline per channel |
| diff_i | input | NCH*16 | Difference count per channel |
| chan_stat_i | input | 8 | Channel status byte |
| out_stat_i | input | 8 | Output status byte |
| tx_o | output | NCH | Serial line per channel pin, idle high |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench targets several corner cases:
- Several requests raised at once. A wrong priority sends the frame on the wrong pin.
- Requests changed mid-frame. A selection that is not latched moves the frame to another line part way through.
- Inputs changed mid-frame, after a snapshot that should have frozen them. A design that reads live data sends a mix of two value sets.
- A second strobe during a frame, and a strobe held across the frame boundary. A design that restarts or drops a frame shows the wrong busy length or the wrong frame count.
- All-ones and all-zero words. These expose a swapped byte order or a reversed bit order, since every bit time is compared against a behavioural model.

// File: rtl/telem_pkg.sv
package telem_pkg;
  localparam logic [7:0] HDR_A    = 8'h0D;
  localparam logic [7:0] HDR_B    = 8'h0A;
  localparam logic [7:0] PAD_BYTE = 8'h00;
  localparam logic [7:0] END_BYTE = 8'hFF;
  localparam int         BITS_PER_CHAR = 10;

  function automatic int frame_bytes(input int nch);
    return 8 * nch + 9;
  endfunction
endpackage

// File: rtl/telem_pin_sel.sv
module telem_pin_sel #(
  parameter int NCH   = 4,
  parameter int SEL_W = 2
) (
  input  logic [NCH-1:0]   req_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             any_o
);
  always_comb begin
    sel_o = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (req_i[k]) sel_o = SEL_W'(k);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/telem_frame_mux.sv
module telem_frame_mux
  import telem_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        fw_i,
  input  logic [NCH*8-1:0]  cap_i,
  input  logic [NCH*16-1:0] raw_i,
  input  logic [NCH*16-1:0] base_i,
  input  logic [NCH*16-1:0] diff_i,
  input  logic [7:0]        cstat_i,
  input  logic [7:0]        ostat_i,
  output logic [7:0]        byte_o
);
  localparam int CAP_BASE  = 4;
  localparam int WORD_BASE = CAP_BASE + 2 * NCH;
  localparam int STAT_BASE = WORD_BASE + 6 * NCH;
  localparam int TRL_BASE  = STAT_BASE + 2;

  int          pos, off, grp, ch;
  logic [15:0] word;

  always_comb begin
    pos    = int'(idx_i);
    off    = 0;
    grp    = 0;
    ch     = 0;
    word   = '0;
    byte_o = PAD_BYTE;
    if (pos == 0)      byte_o = HDR_A;
    else if (pos == 1) byte_o = HDR_B;
    else if (pos == 2) byte_o = PAD_BYTE;
    else if (pos == 3) byte_o = fw_i;
    else if (pos < WORD_BASE) begin
      off = pos - CAP_BASE;
      ch  = off / 2;
      if (off % 2 == 1) byte_o = cap_i[ch*8 +: 8];
    end else if (pos < STAT_BASE) begin
      off = pos - WORD_BASE;
      grp = off / (2 * NCH);
      ch  = (off % (2 * NCH)) / 2;
      case (grp)
        0:       word = raw_i[ch*16 +: 16];
        1:       word = base_i[ch*16 +: 16];
        default: word = diff_i[ch*16 +: 16];
      endcase
      byte_o = (off % 2 == 0) ? word[15:8] : word[7:0];
    end else if (pos == STAT_BASE)     byte_o = cstat_i;
    else if (pos == STAT_BASE + 1)     byte_o = ostat_i;
    else if (pos == TRL_BASE)          byte_o = PAD_BYTE;
    else                               byte_o = END_BYTE;
  end
endmodule

// File: rtl/telem_bit_tx.sv
module telem_bit_tx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       run_i,
  input  logic [7:0] byte_i,
  output logic       line_o,
  output logic       byte_end_o
);
  localparam int DIV_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_BIT - 1);
  localparam logic [3:0]       STOP_POS = 4'd9;

  logic [DIV_W-1:0] div_q, div_d;
  logic [3:0]       bit_q, bit_d;
  logic [3:0]       data_pos;
  logic             tick;

  assign tick = run_i && (div_q == DIV_LAST);

  always_comb begin
    div_d = div_q;
    bit_d = bit_q;
    if (load_i) begin
      div_d = '0;
      bit_d = '0;
    end else if (run_i) begin
      if (tick) begin
        div_d = '0;
        bit_d = (bit_q == STOP_POS) ? 4'd0 : bit_q + 4'd1;
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      bit_q <= '0;
    end else begin
      div_q <= div_d;
      bit_q <= bit_d;
    end
  end

  assign data_pos   = bit_q - 4'd1;
  assign line_o     = (bit_q == 4'd0) ? 1'b0 :
                      (bit_q == STOP_POS) ? 1'b1 : byte_i[data_pos[2:0]];
  assign byte_end_o = tick && (bit_q == STOP_POS);

  // R7
  frame_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (bit_q == 4'd0 && div_q == '0));
  // R7
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= STOP_POS);
endmodule

// File: rtl/telem_frame_tx.sv
module telem_frame_tx
  import telem_pkg::*;
#(
  parameter int NCH          = 4,
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NCH-1:0]    req_i,
  input  logic [7:0]        fw_rev_i,
  input  logic [NCH*8-1:0]  cap_i,
  input  logic [NCH*16-1:0] raw_i,
  input  logic [NCH*16-1:0] base_i,
  input  logic [NCH*16-1:0] diff_i,
  input  logic [7:0]        chan_stat_i,
  input  logic [7:0]        out_stat_i,
  output logic [NCH-1:0]    tx_o,
  output logic              busy_o
);
  localparam int SEL_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NBYTES = frame_bytes(NCH);
  localparam int IDX_W  = $clog2(NBYTES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [SEL_W-1:0] sel_q, sel_d, pick;
  logic             req_any, accept, byte_end, line;
  logic [7:0]       cur_byte;

  logic [7:0]        fw_q, cstat_q, ostat_q;
  logic [NCH*8-1:0]  cap_q;
  logic [NCH*16-1:0] raw_q, base_q, diff_q;

  telem_pin_sel #(.NCH(NCH), .SEL_W(SEL_W)) u_sel (
    .req_i(req_i), .sel_o(pick), .any_o(req_any));

  assign accept = start_i && !busy_q && req_any;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sel_d  = sel_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
      sel_d  = pick;
    end else if (byte_end) begin
      if (idx_q == LAST_IDX) busy_d = 1'b0;
      else                   idx_d  = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sel_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_q    <= '0;
      cap_q   <= '0;
      raw_q   <= '0;
      base_q  <= '0;
      diff_q  <= '0;
      cstat_q <= '0;
      ostat_q <= '0;
    end else if (accept) begin
      fw_q    <= fw_rev_i;
      cap_q   <= cap_i;
      raw_q   <= raw_i;
      base_q  <= base_i;
      diff_q  <= diff_i;
      cstat_q <= chan_stat_i;
      ostat_q <= out_stat_i;
    end
  end

  telem_frame_mux #(.NCH(NCH), .IDX_W(IDX_W)) u_mux (
    .idx_i(idx_q), .fw_i(fw_q), .cap_i(cap_q), .raw_i(raw_q),
    .base_i(base_q), .diff_i(diff_q), .cstat_i(cstat_q),
    .ostat_i(ostat_q), .byte_o(cur_byte));

  telem_bit_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_bit (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .run_i(busy_q),
    .byte_i(cur_byte), .line_o(line), .byte_end_o(byte_end));

  for (genvar k = 0; k < NCH; k++) begin : g_pin
    assign tx_o[k] = (busy_q && sel_q == SEL_W'(k)) ? line : 1'b1;
  end

  assign busy_o = busy_q;

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (&tx_o));
  // R8
  one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~tx_o) <= 1);
  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(sel_q));
  // R12
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(raw_q) && $stable(base_q) && $stable(diff_q) && $stable(fw_q)));
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(idx_q == LAST_IDX));
endmodule

// File: tb/tb_telem_frame_tx.sv
module tb_telem_frame_tx;
  localparam int NCH   = 4;
  localparam int CPB   = 4;
  localparam int NBYTE = 41;
  localparam int TOTAL = NBYTE * 10 * CPB;

  logic              clk, rst_n, start_i;
  logic [NCH-1:0]    req_i;
  logic [7:0]        fw_rev_i, chan_stat_i, out_stat_i;
  logic [NCH*8-1:0]  cap_i;
  logic [NCH*16-1:0] raw_i, base_i, diff_i;
  logic [NCH-1:0]    tx_o;
  logic              busy_o;

  int checks = 0, failures = 0;
  bit done = 0, chk_en = 0;

  telem_frame_tx #(.NCH(NCH), .CLKS_PER_BIT(CPB)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
    .fw_rev_i(fw_rev_i), .cap_i(cap_i), .raw_i(raw_i), .base_i(base_i),
    .diff_i(diff_i), .chan_stat_i(chan_stat_i), .out_stat_i(out_stat_i),
    .tx_o(tx_o), .busy_o(busy_o));

  initial clk = 0;
  always #2 clk = ~clk;

  // behavioural reference model
  bit         m_busy = 0;
  int         m_cnt = 0, m_pin = 0;
  bit         exp_bits[$];
  logic [7:0] fb[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0;
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == TOTAL) m_busy = 0;
    end else if (start_i && req_i != 0) begin
      m_busy = 1; m_cnt = 0;
      m_pin = 0;
      while (!req_i[m_pin]) m_pin++;
      fb.delete();
      fb.push_back(8'h0D); fb.push_back(8'h0A);
      fb.push_back(8'h00); fb.push_back(fw_rev_i);
      for (int c = 0; c < NCH; c++) begin
        fb.push_back(8'h00); fb.push_back(cap_i[c*8 +: 8]);
      end
      for (int c = 0; c < NCH; c++) begin
        fb.push_back(raw_i[c*16+8 +: 8]); fb.push_back(raw_i[c*16 +: 8]);
      end
      for (int c = 0; c < NCH; c++) begin
        fb.push_back(base_i[c*16+8 +: 8]); fb.push_back(base_i[c*16 +: 8]);
      end
      for (int c = 0; c < NCH; c++) begin
        fb.push_back(diff_i[c*16+8 +: 8]); fb.push_back(diff_i[c*16 +: 8]);
      end
      fb.push_back(chan_stat_i); fb.push_back(out_stat_i);
      fb.push_back(8'h00); fb.push_back(8'hFF); fb.push_back(8'hFF);
      exp_bits.delete();
      foreach (fb[b]) begin
        exp_bits.push_back(1'b0);
        for (int j = 0; j < 8; j++) exp_bits.push_back(fb[b][j]);
        exp_bits.push_back(1'b1);
      end
    end
  end

  function automatic string tag_of(int bitno);
    int b = bitno / 10;
    int p = bitno % 10;
    if (p == 0 || p == 9) return "R7";
    if (b < 2)  return "R1";
    if (b < 4)  return "R2";
    if (b < 12) return "R3";
    if (b < 36) return "R4";
    if (b < 38) return "R5";
    return "R6";
  endfunction

  int busy_len = 0, frames = 0;
  bit prev_busy = 0;

  always @(negedge clk) begin
    if (rst_n && chk_en && !done) begin
      checks++;
      if (busy_o !== m_busy) begin
        failures++;
        $display("FAIL R10 busy_o actual=%0b expected=%0b", busy_o, m_busy);
      end
      for (int k = 0; k < NCH; k++) begin
        logic e;
        string t;
        e = 1'b1;
        t = (m_busy) ? "R8" : "R9";
        if (m_busy && k == m_pin) begin
          e = exp_bits[m_cnt / CPB];
          t = tag_of(m_cnt / CPB);
        end
        checks++;
        if (tx_o[k] !== e) begin
          failures++;
          $display("FAIL %s tx_o[%0d] actual=%0b expected=%0b cnt=%0d", t, k, tx_o[k], e, m_cnt);
        end
      end
      if (busy_o && !prev_busy) begin
        frames++;
        busy_len = 0;
      end
      if (busy_o) busy_len++;
      if (!busy_o && prev_busy) begin
        checks++;
        if (busy_len != TOTAL) begin
          failures++;
          $display("FAIL R10 busy length actual=%0d expected=%0d", busy_len, TOTAL);
        end
      end
      prev_busy = busy_o;
    end
  end

  task automatic set_vals(input int s);
    fw_rev_i    = 8'(s * 17 + 3);
    chan_stat_i = 8'(s * 3 + 1);
    out_stat_i  = 8'(~s);
    for (int c = 0; c < NCH; c++) begin
      cap_i[c*8 +: 8]   = 8'(s * 5 + c * 9 + 1);
      raw_i[c*16 +: 16] = 16'(s * 4660 + c * 257);
      base_i[c*16 +: 16] = ~raw_i[c*16 +: 16];
      diff_i[c*16 +: 16] = raw_i[c*16 +: 16] ^ 16'hA5C3;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    rst_n = 0; start_i = 0; req_i = '0;
    set_vals(0);
    wait_cyc(3);
    check_val("R10 reset busy", int'(busy_o), 0);
    check_val("R9 reset lines", int'(tx_o), 15);
    rst_n = 1;
    chk_en = 1;
    wait_cyc(2);

    // R11: start with no request starts nothing
    start_i = 1; wait_cyc(1); start_i = 0;
    wait_cyc(5);
    check_val("R11 no request busy", int'(busy_o), 0);

    // Frame A on pin 1, with mid-frame disturbance (R11, R12, R8)
    set_vals(1); req_i = 4'b0110;
    start_i = 1; wait_cyc(1); start_i = 0;
    wait_cyc(100);
    start_i = 1; set_vals(2); req_i = 4'b0001;
    wait_cyc(1); start_i = 0;
    wait_cyc(20);
    check_val("R8 pin0 idle during pin1 frame", int'(tx_o[0]), 1);
    wait_cyc(TOTAL);
    check_val("R10 frame A done", int'(busy_o), 0);

    // Frame B on pin 3 with extreme words (R4, R7)
    set_vals(3);
    for (int c = 0; c < NCH; c++) begin
      raw_i[c*16 +: 16]  = 16'hFFFF;
      base_i[c*16 +: 16] = 16'h0000;
      diff_i[c*16 +: 16] = (c % 2 == 0) ? 16'h8000 : 16'h0001;
    end
    req_i = 4'b1000;
    start_i = 1; wait_cyc(1); start_i = 0;
    wait_cyc(TOTAL + 5);

    // Frame C: all requests, start held across the frame boundary (R11)
    set_vals(4); req_i = 4'b1111;
    start_i = 1;
    wait_cyc(TOTAL + 10);
    start_i = 0;
    wait_cyc(TOTAL + 5);
    check_val("R11 frame count", frames, 4);
    check_val("R9 final idle lines", int'(tx_o), 15);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule